// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block watches an eight-bit group of port pins and turns selected transitions on them into a single interrupt request for a processor. Each pin passes through a two-stage synchroniser. A per-pin polarity bit then decides whether a rising or a falling transition counts as the active edge. When an active edge is found, the pin's event flag latches. It stays set until software removes it, whether or not that pin's interrupt is enabled.

Software reaches three eight-bit registers through a small synchronous port. Each register has one bit per pin: interrupt mask (address 0), edge polarity (address 1) and event flags (address 2). Software clears event flags by writing ones to them. The interrupt request is the OR, over all pins, of each flag ANDed with its mask bit. A parameter builds a half-width variant in which only pins 3 to 0 are implemented.

Top module: `pin_edge_irq`

## Requirements
- R1: After a clock edge with `rst` high, the mask, polarity and flag registers all read 0x00 and `irq_o` is low.
- R2: A write to address 0 stores `wdata_i` in the mask register. Bit i set to 1 lets flag i drive the interrupt. Reading address 0 returns the stored value.
- R3: A write to address 1 stores the polarity register. Bit i = 1 makes a low-to-high transition of pin i active, and bit i = 0 makes a high-to-low transition active. Transitions of the opposite direction set no flag.
- R4: Reading address 2 returns the flag register. Bit i becomes 1 at the second clock edge after the edge that first samples the new pin level. It does not read as 1 one clock earlier.
- R5: Flags latch even when the matching mask bit is 0. In that case `irq_o` stays low.
- R6: Writing address 2 clears every flag bit whose `wdata_i` bit is 1. Flag bits whose `wdata_i` bit is 0 are unchanged.
- R7: If an active edge on pin i is recorded in the same cycle as a write-1 clear of flag i, the flag ends up set.
- R8: `irq_o` is high exactly when some bit i has both flag i and mask bit i equal to 1. It is combinational from the registers.
- R9: With `REDUCED` = 1, bits 7 to 4 of all three registers read 0 and ignore writes, and transitions on pins 7 to 4 set no flag.
- R10: Address 3 reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous port pin levels |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe, takes effect at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
A newly detected edge and a software clear of the same flag bit can land on the same clock edge. The bench forces this collision by counting clocks from the pin change: it drives the write-1 clear so that the write is sampled on exactly the edge where the synchronised transition is recorded. It then reads the flag back as set. A long random phase can also line these two events up by chance, and there a behavioural reference model judges the outcome on every clock.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;

    typedef logic [PORT_W-1:0] port_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK  = 2'd0,
        SEL_POL   = 2'd1,
        SEL_FLAG  = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        port_vec_t mask;
        port_vec_t pol;
        port_vec_t flag;
    } ctrl_regs_t;

    // Bits that exist in the chosen variant
    function automatic port_vec_t impl_bits(input bit reduced);
        port_vec_t all_ones;
        all_ones = '1;
        return reduced ? (all_ones >> (PORT_W / 2)) : all_ones;
    endfunction

endpackage

// File: rtl/pei_edge_detect.sv
module pei_edge_detect
    import pin_edge_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_vec_t pin_i,
    input  port_vec_t pol_i,
    output port_vec_t edge_o
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic meta_q;
        logic stab_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[i];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        // Polarity 1: low-to-high counts; polarity 0: high-to-low counts
        assign edge_o[i] = pol_i[i] ? (stab_q & ~prev_q) : (~stab_q & prev_q);
    end

endmodule

// File: rtl/pei_regs.sv
module pei_regs
    import pin_edge_irq_pkg::*;
#(
    parameter port_vec_t IMPL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  port_vec_t         wdata_i,
    input  port_vec_t         edge_i,
    output ctrl_regs_t        regs_o,
    output port_vec_t         rdata_o
);

    ctrl_regs_t regs_q;
    reg_sel_e   sel;
    port_vec_t  clr_bits;
    port_vec_t  hit_bits;

    assign sel      = reg_sel_e'(addr_i);
    assign clr_bits = (wr_en_i && sel == SEL_FLAG) ? wdata_i : '0;
    assign hit_bits = edge_i & IMPL;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            // A new edge wins over a clear of the same bit
            regs_q.flag <= (regs_q.flag & ~clr_bits) | hit_bits;
            if (wr_en_i && sel == SEL_MASK) regs_q.mask <= wdata_i & IMPL;
            if (wr_en_i && sel == SEL_POL)  regs_q.pol  <= wdata_i & IMPL;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_MASK:  rdata_o = regs_q.mask;
            SEL_POL:   rdata_o = regs_q.pol;
            SEL_FLAG:  rdata_o = regs_q.flag;
            SEL_SPARE: rdata_o = '0;
        endcase
    end

    assign regs_o = regs_q;

    // A flag bit only rises where an edge was reported
    assert_flag_source_R4: assert property (@(posedge clk) disable iff (rst)
        ((regs_q.flag & ~$past(regs_q.flag) & ~$past(edge_i)) == '0));

    // Write-1 clears bits that saw no edge
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel == SEL_FLAG) |=> ((regs_q.flag & $past(wdata_i & ~edge_i & IMPL)) == '0));

    // Edge beats a simultaneous clear
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ((edge_i & IMPL) != '0) |=> ((regs_q.flag & $past(edge_i & IMPL)) == $past(edge_i & IMPL)));

    // Mask write lands one clock later
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel == SEL_MASK) |=> (regs_q.mask == $past(wdata_i & IMPL)));

    // Spare address leaves the mask and polarity alone
    assert_spare_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel == SEL_SPARE) |=> ($stable(regs_q.mask) && $stable(regs_q.pol)));

    if (IMPL != '1) begin : g_reduced_chk
        assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
            ((regs_q.flag | regs_q.mask | regs_q.pol) & ~IMPL) == '0);
    end

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
    import pin_edge_irq_pkg::*;
#(
    parameter bit REDUCED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        pin_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);

    localparam port_vec_t IMPL = impl_bits(REDUCED);

    port_vec_t  edge_vec;
    ctrl_regs_t regs;

    pei_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .pol_i  (regs.pol),
        .edge_o (edge_vec)
    );

    pei_regs #(.IMPL(IMPL)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .edge_i  (edge_vec),
        .regs_o  (regs),
        .rdata_o (rdata_o)
    );

    assign irq_o = |(regs.flag & regs.mask);

    // The request only rises after an edge or a register write
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(edge_vec) != '0 || $past(wr_en_i)));

endmodule

// File: tb/sim_pin_edge_irq.sv
module sim_pin_edge_irq;
    import pin_edge_irq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pins = '0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rd0, rd1;
    logic       irq0, irq1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    pin_edge_irq #(.REDUCED(1'b0)) u0 (
        .clk(clk), .rst(rst), .pin_i(pins), .addr_i(addr),
        .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rd0), .irq_o(irq0));

    pin_edge_irq #(.REDUCED(1'b1)) u1 (
        .clk(clk), .rst(rst), .pin_i(pins), .addr_i(addr),
        .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rd1), .irq_o(irq1));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference: index 0 full, index 1 reduced
    logic [7:0] m_en [2];
    logic [7:0] m_pol[2];
    logic [7:0] m_flg[2];
    logic [7:0] hist[$];

    always @(posedge clk) begin
        logic [7:0] now_lvl, old_lvl, act, clr, keep;
        if (rst) begin
            for (int m = 0; m < 2; m++) begin
                m_en[m] = '0; m_pol[m] = '0; m_flg[m] = '0;
            end
            hist = '{8'h00, 8'h00, 8'h00};
        end else begin
            now_lvl = hist[1];
            old_lvl = hist[2];
            clr = (wr && addr == 2'd2) ? wdata : 8'h00;
            for (int m = 0; m < 2; m++) begin
                keep = (m == 1) ? 8'h0F : 8'hFF;
                act = (m_pol[m] & now_lvl & ~old_lvl) | (~m_pol[m] & ~now_lvl & old_lvl);
                m_flg[m] = ((m_flg[m] & ~clr) | act) & keep;
                if (wr && addr == 2'd0) m_en[m]  = wdata & keep;
                if (wr && addr == 2'd1) m_pol[m] = wdata & keep;
            end
            hist.push_front(pins);
            void'(hist.pop_back());
        end
    end

    function automatic logic [7:0] model_rd(input int m);
        case (addr)
            2'd0:    return m_en[m];
            2'd1:    return m_pol[m];
            2'd2:    return m_flg[m];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to the next falling edge and compare against the model
    task automatic cycle();
        string tag;
        @(negedge clk);
        if (rst) return;
        case (addr)
            2'd0: tag = "R2";
            2'd1: tag = "R3";
            2'd2: tag = "R4";
            default: tag = "R10";
        endcase
        check(tag, rd0, model_rd(0));
        check("R9", rd1, model_rd(1));
        check("R8", {7'd0, irq0}, {7'd0, |(m_flg[0] & m_en[0])});
        check("R9", {7'd0, irq1}, {7'd0, |(m_flg[1] & m_en[1])});
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cycle();
        wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a);
        addr = a;
        #1;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) cycle();
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0]);
            check("R1", rd0, 8'h00);
        end
        check("R1", {7'd0, irq0}, 8'h00);

        // R2 and R9: mask write, reduced drops upper bits
        wr_reg(2'd0, 8'hA5);
        peek(2'd0);
        check("R2", rd0, 8'hA5);
        check("R9", rd1, 8'h05);
        wr_reg(2'd0, 8'h00);

        // R3/R4: low nibble rising, high nibble falling
        wr_reg(2'd1, 8'h0F);
        pins = 8'hFF;
        cycle(); cycle();
        peek(2'd2);
        check("R4", rd0, 8'h00);
        cycle();
        check("R4", rd0, 8'h0F);
        check("R5", {7'd0, irq0}, 8'h00);
        pins = 8'h00;
        repeat (3) cycle();
        check("R3", rd0, 8'hFF);
        check("R9", rd1, 8'h0F);

        // R6: write 0 keeps, write 1 clears
        wr_reg(2'd2, 8'h00);
        peek(2'd2);
        check("R6", rd0, 8'hFF);
        wr_reg(2'd2, 8'h3C);
        peek(2'd2);
        check("R6", rd0, 8'hC3);

        // R8: request follows flag AND mask
        wr_reg(2'd0, 8'h3C);
        #1 check("R8", {7'd0, irq0}, 8'h00);
        wr_reg(2'd0, 8'h01);
        #1 check("R8", {7'd0, irq0}, 8'h01);
        wr_reg(2'd2, 8'hFF);
        #1 check("R8", {7'd0, irq0}, 8'h00);

        // R7: edge recorded on the same edge as the clear
        pins = 8'h01;
        cycle(); cycle();
        wr_reg(2'd2, 8'h01);
        peek(2'd2);
        check("R7", rd0, 8'h01);
        check("R7", {7'd0, irq0}, 8'h01);

        // R10: spare address
        wr_reg(2'd3, 8'hFF);
        peek(2'd3);
        check("R10", rd0, 8'h00);
        peek(2'd0);
        check("R10", rd0, 8'h01);
        peek(2'd1);
        check("R10", rd0, 8'h0F);

        // Random traffic against the model
        for (int n = 0; n < 600; n++) begin
            pins  = 8'($urandom);
            addr  = 2'($urandom);
            wdata = 8'($urandom);
            wr    = ($urandom % 4) == 0;
            cycle();
        end
        wr = 1'b0;
        cycle();

        done = 1'b1;
        report();
    end

endmodule